// File: doc/BRIEF.md
# Paged DMA Address and Count Engine

This block is the transfer datapath of one channel in a legacy-style DMA controller. Software loads a 16-bit start address, a 16-bit transfer count, a low page byte and a high page byte. The engine then presents a 32-bit physical address for every accepted transfer. After each transfer it steps the address and the count. A channel works in byte units, where one address step is one byte, or in word units, where one address step is one 16-bit word. In word units, physical bit 0 is always zero.

The count register holds the number of transfers minus one. The transfer that finds the count at zero raises terminal count, and the count then reads 0xFFFF. Without auto-initialise the channel then stops accepting transfers. With auto-initialise it reloads the address and the count from the values last written and carries on. By default the 16-bit address wraps inside its page. Writing the high page byte arms an extended mode. In that mode a carry out of the address register increments the page pair, so one block can cross a 64K boundary (byte units) or a 128K boundary (word units).

Transfers use a valid/ready handshake. `xfer_valid` may be held for any number of cycles. A transfer completes in each cycle where `xfer_valid` and `xfer_ready` are both high. `xfer_ready` is high only while the channel is active. `phys_addr` and `tc` belong to the transfer completing in that same cycle. All register writes are plain strobes.

Top module: `dma_page_engine`

## Requirements
- R1: A synchronous reset clears the address, the count, both page bytes and the base copies. It also drops `xfer_ready`, `tc` and `ext_armed`, so `phys_addr` reads 0 and `cur_count` reads 0.
- R2: In byte units (`word_mode`=0), `phys_addr` = {high page[7:0], low page[7:0], address[15:0]}.
- R3: In word units (`word_mode`=1), `phys_addr` = {high page[7:0], low page[7:1], address[15:0], 1'b0}. Low page bit 0 has no effect on `phys_addr`.
- R4: Each completed transfer advances the address register by one, the cycle after the transfer. `phys_addr` therefore grows by 1 in byte units and by 2 in word units.
- R5: Writing the count loads `cur_count` and raises `xfer_ready` from the next cycle. Each completed transfer lowers `cur_count` by one, so a loaded value N allows N+1 transfers.
- R6: `tc` is high during exactly the completed transfer in which `cur_count` is 0x0000. After that transfer, without auto-initialise, `cur_count` reads 0xFFFF.
- R7: Without auto-initialise, `xfer_ready` is low from the cycle after terminal count. A held `xfer_valid` then changes neither `phys_addr` nor `cur_count` and raises no `tc`.
- R8: With `auto_init`=1, the cycle after terminal count shows the address and the count last written. `xfer_ready` stays high.
- R9: While not armed, an address step from 0xFFFF gives 0x0000 and leaves both page bytes unchanged.
- R10: Writing the high page byte sets `ext_armed`. Writing the low page byte alone clears it. While armed, an address step from 0xFFFF adds 1 (byte units) or 2 (word units) to the 16-bit {high page, low page} pair.
- R11: A register write in the same cycle as a completed transfer takes priority for the register it writes. The other registers still step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | 1 = word units, 0 = byte units |
| auto_init | input | 1 | Reload from base copies at terminal count |
| addr_we | input | 1 | Write strobe for the address register |
| addr_wdata | input | 16 | Start address in channel units |
| cnt_we | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 16 | Transfers minus one |
| page_we | input | 1 | Write strobe for the low page byte (disarms) |
| page_wdata | input | 8 | Low page byte |
| hpage_we | input | 1 | Write strobe for the high page byte (arms) |
| hpage_wdata | input | 8 | High page byte |
| xfer_valid | input | 1 | Transfer request |
| xfer_ready | output | 1 | Channel active; transfer accepted when both high |
| phys_addr | output | 32 | Physical address of the current transfer |
| cur_count | output | 16 | Remaining transfers minus one |
| tc | output | 1 | Terminal count, during the last transfer |
| ext_armed | output | 1 | Boundary carry into the page pair enabled |

## Verification
A wrong address or page register shows up on `phys_addr` at once, because the output is a combinational view of them. A wrong step or a lost carry shows up on the transfer that follows. A corrupted count or active flag is often invisible on `cur_count` until the block ends. It then shows as `tc` firing on the wrong transfer, or `xfer_ready` staying high or dropping one transfer early or late. So the bench reads the count after every step. It also probes the exact transfer where the count passes zero, and the exact step where the address passes 0xFFFF, with the extension both armed and disarmed.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned PAGE_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 16;

  typedef enum logic {
    UNIT_BYTE = 1'b0,
    UNIT_WORD = 1'b1
  } unit_e;

  // Page-pair increment applied on an armed address carry.
  function automatic logic [1:0] page_carry_step(input unit_e unit);
    return (unit == UNIT_WORD) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/dma_count_stepper.sv
module dma_count_stepper #(
  parameter int unsigned CNT_W = dma_pg_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_init,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             xfer_valid,
  output logic             active,
  output logic             fire,
  output logic             tc,
  output logic [CNT_W-1:0] cur_count
);
  logic [CNT_W-1:0] base_count;

  assign fire = xfer_valid && active;
  assign tc   = fire && (cur_count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_count  <= '0;
      base_count <= '0;
      active     <= 1'b0;
    end else if (cnt_we) begin
      cur_count  <= cnt_wdata;
      base_count <= cnt_wdata;
      active     <= 1'b1;
    end else if (fire) begin
      if (tc && auto_init) begin
        cur_count <= base_count;
      end else begin
        cur_count <= cur_count - 1'b1;
        if (tc) active <= 1'b0;
      end
    end
  end

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && !cnt_we && cur_count != '0) |=> (cur_count == $past(cur_count) - 1'b1));

  p_stop_after_tc_r7: assert property (@(posedge clk) disable iff (rst)
    (tc && !auto_init && !cnt_we) |=> (!active && cur_count == '1));

  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (tc && auto_init && !cnt_we) |=> (active && cur_count == base_count));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!active && !cnt_we) |=> $stable(cur_count));
endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
  import dma_pg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  unit_e             unit,
  input  logic              step,
  input  logic              reload,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              hpage_we,
  input  logic [PAGE_W-1:0] hpage_wdata,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [PAGE_W-1:0] page_lo,
  output logic [PAGE_W-1:0] page_hi,
  output logic              armed
);
  localparam int unsigned PAIR_W = 2 * PAGE_W;

  logic [ADDR_W-1:0] base_addr;
  logic              addr_moves;
  logic              carry_out;
  logic [PAIR_W-1:0] pair_next;

  assign addr_moves = step && !addr_we && !reload;
  assign carry_out  = addr_moves && armed && (cur_addr == '1);
  assign pair_next  = {page_hi, page_lo} + PAIR_W'(page_carry_step(unit));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      base_addr <= '0;
    end else if (addr_we) begin
      cur_addr  <= addr_wdata;
      base_addr <= addr_wdata;
    end else if (reload) begin
      cur_addr  <= base_addr;
    end else if (step) begin
      cur_addr  <= cur_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_lo <= '0;
      page_hi <= '0;
      armed   <= 1'b0;
    end else begin
      if (page_we)        page_lo <= page_wdata;
      else if (carry_out) page_lo <= pair_next[PAGE_W-1:0];
      if (hpage_we)       page_hi <= hpage_wdata;
      else if (carry_out) page_hi <= pair_next[PAIR_W-1:PAGE_W];
      if (hpage_we)       armed   <= 1'b1;
      else if (page_we)   armed   <= 1'b0;
    end
  end

  p_wrap_in_page_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !armed && !page_we && !hpage_we) |=> ($stable(page_lo) && $stable(page_hi)));

  p_arm_on_high_r10: assert property (@(posedge clk) disable iff (rst)
    hpage_we |=> armed);

  p_disarm_on_low_r10: assert property (@(posedge clk) disable iff (rst)
    (page_we && !hpage_we) |=> !armed);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !addr_we && !reload) |=> (cur_addr == $past(cur_addr) + 1'b1));
endmodule

// File: rtl/dma_phys_compose.sv
module dma_phys_compose
  import dma_pg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  localparam int unsigned PHYS_W = ADDR_W + 2 * PAGE_W
) (
  input  unit_e             unit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [PAGE_W-1:0] page_lo,
  input  logic [PAGE_W-1:0] page_hi,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (unit == UNIT_WORD)
      phys = {page_hi, page_lo[PAGE_W-1:1], cur_addr, 1'b0};
    else
      phys = {page_hi, page_lo, cur_addr};
  end
endmodule

// File: rtl/dma_page_engine.sv
module dma_page_engine
  import dma_pg_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  localparam int unsigned PHYS_W = ADDR_W + 2 * PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_mode,
  input  logic              auto_init,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_wdata,
  input  logic              hpage_we,
  input  logic [PAGE_W-1:0] hpage_wdata,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              tc,
  output logic              ext_armed
);
  unit_e             unit;
  logic              fire;
  logic              reload;
  logic [ADDR_W-1:0] cur_addr;
  logic [PAGE_W-1:0] page_lo;
  logic [PAGE_W-1:0] page_hi;

  assign unit   = word_mode ? UNIT_WORD : UNIT_BYTE;
  assign reload = tc && auto_init && !cnt_we;

  dma_count_stepper #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .auto_init  (auto_init),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .xfer_valid (xfer_valid),
    .active     (xfer_ready),
    .fire       (fire),
    .tc         (tc),
    .cur_count  (cur_count)
  );

  dma_addr_stepper #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk         (clk),
    .rst         (rst),
    .unit        (unit),
    .step        (fire),
    .reload      (reload),
    .addr_we     (addr_we),
    .addr_wdata  (addr_wdata),
    .page_we     (page_we),
    .page_wdata  (page_wdata),
    .hpage_we    (hpage_we),
    .hpage_wdata (hpage_wdata),
    .cur_addr    (cur_addr),
    .page_lo     (page_lo),
    .page_hi     (page_hi),
    .armed       (ext_armed)
  );

  dma_phys_compose #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_compose (
    .unit     (unit),
    .cur_addr (cur_addr),
    .page_lo  (page_lo),
    .page_hi  (page_hi),
    .phys     (phys_addr)
  );

  p_tc_only_on_xfer_r6: assert property (@(posedge clk) disable iff (rst)
    tc |-> (xfer_valid && xfer_ready));

  p_no_accept_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!xfer_ready && !addr_we && !page_we && !hpage_we) |=> $stable(phys_addr));
endmodule

// File: tb/dma_page_engine_tb_top.sv
`timescale 1ns/1ps
module dma_page_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0, auto_init = 1'b0;
  logic        addr_we = 1'b0, cnt_we = 1'b0, page_we = 1'b0, hpage_we = 1'b0;
  logic [15:0] addr_wdata = '0, cnt_wdata = '0;
  logic [7:0]  page_wdata = '0, hpage_wdata = '0;
  logic        xfer_valid = 1'b0;
  logic        xfer_ready, tc, ext_armed;
  logic [31:0] phys_addr;
  logic [15:0] cur_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_page_engine dut_i (
    .clk(clk), .rst(rst), .word_mode(word_mode), .auto_init(auto_init),
    .addr_we(addr_we), .addr_wdata(addr_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .page_we(page_we), .page_wdata(page_wdata), .hpage_we(hpage_we), .hpage_wdata(hpage_wdata),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .phys_addr(phys_addr),
    .cur_count(cur_count), .tc(tc), .ext_armed(ext_armed)
  );

  // {word, high page, low page, address, expected phys}
  localparam logic [64:0] VEC [6] = '{
    {1'b0, 8'h00, 8'h12, 16'h3456, 32'h0012_3456},
    {1'b0, 8'hAB, 8'hCD, 16'hEF01, 32'hABCD_EF01},
    {1'b1, 8'h00, 8'h12, 16'h3456, 32'h0012_68AC},
    {1'b1, 8'h55, 8'h13, 16'h8000, 32'h5513_0000},
    {1'b1, 8'hFF, 8'hFF, 16'hFFFF, 32'hFFFF_FFFE},
    {1'b0, 8'h01, 8'h00, 16'h0000, 32'h0100_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w_addr(input logic [15:0] v);
    addr_we = 1'b1; addr_wdata = v; @(negedge clk); addr_we = 1'b0;
  endtask
  task automatic w_cnt(input logic [15:0] v);
    cnt_we = 1'b1; cnt_wdata = v; @(negedge clk); cnt_we = 1'b0;
  endtask
  task automatic w_page(input logic [7:0] v);
    page_we = 1'b1; page_wdata = v; @(negedge clk); page_we = 1'b0;
  endtask
  task automatic w_hpage(input logic [7:0] v);
    hpage_we = 1'b1; hpage_wdata = v; @(negedge clk); hpage_we = 1'b0;
  endtask
  task automatic xfer(output logic [31:0] pa, output logic t);
    xfer_valid = 1'b1; #2; pa = phys_addr; t = tc; @(negedge clk); xfer_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic        t;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 phys", phys_addr, 32'h0);
    check("R1 count", {16'h0, cur_count}, 32'h0);
    check("R1 ready/armed/tc", {29'h0, xfer_ready, ext_armed, tc}, 32'h0);

    // R2/R3 composition vectors
    for (int i = 0; i < 6; i++) begin
      word_mode = VEC[i][64];
      w_page(VEC[i][55:48]);
      w_hpage(VEC[i][63:56]);
      w_addr(VEC[i][47:32]);
      check(VEC[i][64] ? "R3 word compose" : "R2 byte compose", phys_addr, VEC[i][31:0]);
    end

    // R5 R6 R7 R9: byte, unarmed, count 2 -> 3 transfers across 0xFFFF
    word_mode = 1'b0; auto_init = 1'b0;
    w_hpage(8'h00);
    w_page(8'h20);
    check("R10 low page disarms", {31'h0, ext_armed}, 32'h0);
    w_addr(16'hFFFE);
    w_cnt(16'h0002);
    check("R5 ready after count write", {31'h0, xfer_ready}, 32'h1);
    xfer(pa, t);
    check("R2 xfer1 addr", pa, 32'h0020_FFFE);
    check("R6 no tc xfer1", {31'h0, t}, 32'h0);
    check("R5 count after xfer1", {16'h0, cur_count}, 32'h1);
    xfer(pa, t);
    check("R4 xfer2 addr", pa, 32'h0020_FFFF);
    xfer(pa, t);
    check("R9 wrap in page", pa, 32'h0020_0000);
    check("R6 tc on last", {31'h0, t}, 32'h1);
    check("R6 count FFFF", {16'h0, cur_count}, 32'h0000_FFFF);
    check("R7 ready low", {31'h0, xfer_ready}, 32'h0);
    xfer(pa, t);
    check("R7 no tc idle", {31'h0, t}, 32'h0);
    check("R7 addr held", phys_addr, 32'h0020_0001);
    check("R7 count held", {16'h0, cur_count}, 32'h0000_FFFF);

    // R10 byte armed crossing
    w_page(8'h20);
    w_hpage(8'h00);
    check("R10 high page arms", {31'h0, ext_armed}, 32'h1);
    w_addr(16'hFFFF);
    w_cnt(16'h0001);
    xfer(pa, t);
    check("R10 byte pre-cross", pa, 32'h0020_FFFF);
    check("R10 byte crossed", phys_addr, 32'h0021_0000);

    // R10 carry into high page
    w_page(8'hFF);
    w_hpage(8'h07);
    w_addr(16'hFFFF);
    w_cnt(16'h0000);
    xfer(pa, t);
    check("R10 carry into high page", phys_addr, 32'h0800_0000);

    // R10 word armed crossing with tc
    word_mode = 1'b1;
    w_page(8'h20);
    w_hpage(8'h00);
    w_addr(16'hFFFF);
    w_cnt(16'h0000);
    xfer(pa, t);
    check("R3 word pre-cross", pa, 32'h0021_FFFE);
    check("R6 tc single xfer", {31'h0, t}, 32'h1);
    check("R10 word crossed 128K", phys_addr, 32'h0022_0000);

    // R4 word step unarmed
    w_page(8'h30);
    w_addr(16'h0010);
    w_cnt(16'h0003);
    xfer(pa, t);
    check("R4 word step", phys_addr - pa, 32'h2);

    // R8 auto-initialise
    word_mode = 1'b0; auto_init = 1'b1;
    w_addr(16'h1000);
    w_cnt(16'h0001);
    xfer(pa, t);
    xfer(pa, t);
    check("R8 tc", {31'h0, t}, 32'h1);
    check("R8 addr reload", phys_addr, 32'h0030_1000);
    check("R8 count reload", {16'h0, cur_count}, 32'h1);
    check("R8 ready stays", {31'h0, xfer_ready}, 32'h1);

    // R11 count write during transfer wins, address still steps
    cnt_we = 1'b1; cnt_wdata = 16'h0005;
    xfer(pa, t);
    cnt_we = 1'b0;
    check("R11 count write wins", {16'h0, cur_count}, 32'h5);
    check("R11 addr still steps", phys_addr, 32'h0030_1001);

    // R1 reset mid-operation
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset clears", {phys_addr[31:0]}, 32'h0);
    check("R1 reset idle", {14'h0, cur_count, xfer_ready, ext_armed}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule